// File: doc/BRIEF.md
# Multi-Descriptor Packet Accumulator

This block sits on the user side, between the port where a DMA engine hands out raw stream descriptors and the port where it takes descriptors back for execution. Each incoming descriptor carries a queue tag, a buffer address, a byte length and two markers for the first and last descriptor of a packet. A packet may be built from several descriptors whose buffers are not contiguous in memory.

The engine can deadlock if it is handed the start of a packet whose end never arrives. It also misbehaves if descriptors from two packets are mixed together. For both reasons the accumulator stores every descriptor in a local FIFO and tracks how many finished packets that FIFO holds. It presents a descriptor at its output only while at least one finished packet is stored. Because the FIFO keeps arrival order, a packet drains as one contiguous run. Descriptors that break the first/last framing are discarded and flagged.

Each descriptor that leaves the block returns one credit toward the engine, tagged with the descriptor's queue.

Top module: `desc_pkt_accum`

## Requirements
- R1: Straight after reset, `out_valid`, `seq_err`, `overflow` and `crd_valid` are 0 and `in_ready` is 1.
- R2: No descriptor is offered at the output while the FIFO holds only descriptors of a packet whose last descriptor (`in_eop`=1) has not yet been accepted.
- R3: Accepted well-framed descriptors leave the block in arrival order. Queue tag, address, length and both markers come out unchanged. While `out_valid` is 1 and `out_ready` is 0, the offered descriptor holds steady.
- R4: Once a packet's first descriptor has been taken at the output, `out_valid` stays 1 until that packet's last descriptor has been taken. No other packet's descriptor comes in between.
- R5: A descriptor with both `in_sop`=1 and `in_eop`=1 is a complete packet. It is offered at the output from the cycle after it is accepted.
- R6: A descriptor accepted with `in_sop`=0 while no packet is open is dropped, and `seq_err` is 1 for the single following cycle.
- R7: A descriptor accepted with `in_sop`=1 while a packet is open is dropped, and `seq_err` pulses for one cycle. The open packet stays open and completes normally.
- R8: `in_ready` is 0 exactly when the FIFO holds DEPTH descriptors, whether or not those descriptors form finished packets.
- R9: `overflow` is 1 while the FIFO is full and holds no finished packet, and 0 while the FIFO is full of finished packets.
- R10: In the cycle after each output handshake, `crd_valid` is 1 for one cycle and `crd_qid` equals the queue tag of the descriptor taken. `crd_valid` is 0 in every other cycle.
- R11: An accepted input and an output handshake in the same cycle both take effect, with no loss, duplication or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming descriptor is valid |
| in_ready | output | 1 | Accumulator can take a descriptor |
| in_qid | input | QW | Queue tag of incoming descriptor |
| in_addr | input | AW | Buffer address |
| in_len | input | LW | Buffer length in bytes |
| in_sop | input | 1 | First descriptor of a packet |
| in_eop | input | 1 | Last descriptor of a packet |
| out_valid | output | 1 | Descriptor of a finished packet offered |
| out_ready | input | 1 | Engine takes the offered descriptor |
| out_qid | output | QW | Queue tag |
| out_addr | output | AW | Buffer address |
| out_len | output | LW | Buffer length |
| out_sop | output | 1 | First-descriptor marker |
| out_eop | output | 1 | Last-descriptor marker |
| crd_valid | output | 1 | One credit returned |
| crd_qid | output | QW | Queue the credit belongs to |
| seq_err | output | 1 | One-cycle pulse: framing violation, descriptor dropped |
| overflow | output | 1 | FIFO full with no finished packet |

## Verification
Two things can land in the same cycle. The first is a push of a new descriptor while a finished packet drains. The second is a packet's last descriptor arriving while another packet's last descriptor is taken, so the finished-packet count must rise and fall in one edge. The bench stores several single-descriptor packets behind a stalled output, then opens the output at the moment it starts feeding a three-descriptor packet. It also runs mixed traffic under a periodic stall pattern. In all of these the outcome is judged against the scoreboard's order and contents, together with the rule that a started packet never pauses and the one-credit-per-descriptor rule.

// File: rtl/desc_pkt_accum.sv
module desc_pkt_accum #(
  parameter int QW    = 12,
  parameter int AW    = 64,
  parameter int LW    = 16,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [QW-1:0] in_qid,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_len,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [QW-1:0] out_qid,
  output logic [AW-1:0] out_addr,
  output logic [LW-1:0] out_len,
  output logic          out_sop,
  output logic          out_eop,
  output logic          crd_valid,
  output logic [QW-1:0] crd_qid,
  output logic          seq_err,
  output logic          overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = QW + AW + LW + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, pkt_cnt;
  logic          open_q;

  wire push_ok = in_valid && in_ready;
  wire seq_ok  = open_q ? !in_sop : in_sop;
  wire wr      = push_ok && seq_ok;
  wire rd      = out_valid && out_ready;

  assign in_ready  = cnt != CW'(DEPTH);
  assign out_valid = pkt_cnt != '0;
  assign overflow  = (cnt == CW'(DEPTH)) && (pkt_cnt == '0);
  assign {out_qid, out_addr, out_len, out_sop, out_eop} = mem[rd_ptr];

  always_ff @(posedge clk)
    if (wr) mem[wr_ptr] <= {in_qid, in_addr, in_len, in_sop, in_eop};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      pkt_cnt   <= '0;
      open_q    <= 1'b0;
      seq_err   <= 1'b0;
      crd_valid <= 1'b0;
      crd_qid   <= '0;
    end else begin
      if (wr) begin
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
        open_q <= !in_eop;
      end
      if (rd) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      cnt       <= cnt + CW'(wr) - CW'(rd);
      pkt_cnt   <= pkt_cnt + CW'(wr && in_eop) - CW'(rd && out_eop);
      seq_err   <= push_ok && !seq_ok;
      crd_valid <= rd;
      if (rd) crd_qid <= out_qid;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_finished_le_stored_R2: assert property (@(posedge clk) disable iff (rst)
    pkt_cnt <= cnt);
  assert_hold_offer_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_qid)));
  assert_packet_unbroken_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_eop) |=> out_valid);
  assert_single_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sop && in_eop && !open_q) |=> out_valid);
  assert_err_after_push_R6: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> $past(in_valid && in_ready));
  assert_overflow_stalls_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (!out_valid && !in_ready));
endmodule

// File: tb/tb_desc_pkt_accum.sv
module tb_desc_pkt_accum;
  localparam int QW = 12, AW = 64, LW = 16, DEPTH = 32;
  localparam int EW = QW + AW + LW + 2;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, in_sop = 0, in_eop = 0;
  logic [QW-1:0] in_qid = '0;
  logic [AW-1:0] in_addr = '0;
  logic [LW-1:0] in_len = '0;
  logic out_valid, out_ready = 0, out_sop, out_eop, crd_valid, seq_err, overflow;
  logic [QW-1:0] out_qid, crd_qid;
  logic [AW-1:0] out_addr;
  logic [LW-1:0] out_len;

  int checks = 0, fails = 0;
  logic [EW-1:0] sb[$];
  logic crd_pend = 0, in_pkt = 0;
  logic [QW-1:0] pend_qid = '0;

  always #5 clk = ~clk;

  desc_pkt_accum #(.QW(QW), .AW(AW), .LW(LW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_qid(in_qid), .in_addr(in_addr), .in_len(in_len), .in_sop(in_sop),
    .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_qid(out_qid), .out_addr(out_addr), .out_len(out_len),
    .out_sop(out_sop), .out_eop(out_eop), .crd_valid(crd_valid),
    .crd_qid(crd_qid), .seq_err(seq_err), .overflow(overflow));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: call at posedge+1; returns at posedge+1 after acceptance
  task automatic send(input int q, input longint a, input int l, input bit s, input bit e, input bit good);
    in_valid = 1; in_qid = QW'(q); in_addr = AW'(a); in_len = LW'(l); in_sop = s; in_eop = e;
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #1;
    if (good) sb.push_back({QW'(q), AW'(a), LW'(l), s, e});
    in_valid = 0;
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; out_ready = 0;
    repeat (2) @(posedge clk); #1 rst = 0;
  endtask

  task automatic drain(input string req);
    out_ready = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sb.size() == 0 && !out_valid) break;
    end
    chk(sb.size() == 0 && !out_valid, req, sb.size(), 0);
    @(posedge clk); #1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      crd_pend = 0; in_pkt = 0;
    end else begin
      if (crd_pend) chk(crd_valid && crd_qid == pend_qid, "R10 credit", {crd_valid, crd_qid}, {1'b1, pend_qid});
      else if (crd_valid) chk(0, "R10 spurious credit", 1, 0);
      if (in_pkt) chk(out_valid, "R4 packet paused", out_valid, 1);
      crd_pend = 0;
      if (out_valid && out_ready) begin
        logic [EW-1:0] got;
        got = {out_qid, out_addr, out_len, out_sop, out_eop};
        if (sb.size() == 0) chk(0, "R3 R4 unexpected output", got, 0);
        else begin
          logic [EW-1:0] exp;
          exp = sb.pop_front();
          chk(got == exp, "R3 R4 order/content", got, exp);
        end
        crd_pend = 1; pend_qid = out_qid;
        if (out_sop && !out_eop) in_pkt = 1;
        if (out_eop) in_pkt = 0;
      end
    end
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(!out_valid && !seq_err && !overflow && !crd_valid && in_ready, "R1 reset",
        {out_valid, seq_err, overflow, crd_valid, in_ready}, 5'b00001);
    @(posedge clk); #1;

    // R2: partial packet held
    out_ready = 1;
    send(1, 'h1000, 64, 1, 0, 1);
    send(1, 'h2000, 64, 0, 0, 1);
    send(1, 'h3000, 64, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R2 held before last", out_valid, 0);
    @(posedge clk); #1;
    send(1, 'h4000, 32, 0, 1, 1);
    @(negedge clk);
    chk(out_valid, "R2 released after last", out_valid, 1);
    @(posedge clk); #1;
    drain("R2 drain");

    // R5: single-descriptor packet
    out_ready = 0;
    send(2, 'h5000, 128, 1, 1, 1);
    @(negedge clk);
    chk(out_valid && out_sop && out_eop, "R5 single offered", {out_valid, out_sop, out_eop}, 3'b111);
    @(posedge clk); #1;
    drain("R5 drain");

    // R6: no SOP while closed
    send(3, 'h6000, 8, 0, 0, 0);
    @(negedge clk);
    chk(seq_err, "R6 err pulse", seq_err, 1);
    chk(!out_valid, "R6 dropped", out_valid, 0);
    @(negedge clk);
    chk(!seq_err, "R6 err one cycle", seq_err, 0);
    @(posedge clk); #1;
    send(3, 'h6100, 8, 0, 1, 0);
    @(negedge clk);
    chk(seq_err && !out_valid, "R6 stray EOP dropped", {seq_err, out_valid}, 2'b10);
    @(posedge clk); #1;

    // R7: SOP while open
    out_ready = 0;
    send(4, 'h7000, 16, 1, 0, 1);
    send(5, 'h7100, 16, 1, 0, 0);
    @(negedge clk);
    chk(seq_err, "R7 err pulse", seq_err, 1);
    @(posedge clk); #1;
    send(4, 'h7200, 16, 0, 1, 1);
    @(negedge clk);
    chk(!seq_err && out_valid, "R7 open packet completes", {seq_err, out_valid}, 2'b01);
    @(posedge clk); #1;
    drain("R7 drain");

    // R11: push during drain
    out_ready = 0;
    for (int i = 0; i < 4; i++) send(6 + i, 'h8000 + i * 'h100, 40 + i, 1, 1, 1);
    out_ready = 1;
    send(10, 'h9000, 20, 1, 0, 1);
    send(10, 'h9100, 20, 0, 0, 1);
    send(11, 'h9200, 20, 1, 1, 0);
    send(10, 'h9300, 20, 0, 1, 1);
    drain("R11 simultaneous push/pop");

    // mixed traffic under periodic stall
    fork
      begin
        for (int p = 0; p < 6; p++) begin
          int n;
          n = (p % 3) + 1;
          for (int k = 0; k < n; k++)
            send(20 + p, 'hA000 + p * 'h1000 + k * 'h40, 100 + k, k == 0, k == n - 1, 1);
        end
      end
      begin
        for (int c = 0; c < 60; c++) begin
          @(posedge clk); #2;
          out_ready = (c % 3) != 1;
        end
      end
    join
    @(posedge clk); #1;
    drain("R3 mixed drain");

    // R8: full of finished packets
    out_ready = 0;
    for (int i = 0; i < DEPTH; i++) send(i, 'hB000 + i, i + 1, 1, 1, 1);
    @(negedge clk);
    chk(!in_ready, "R8 full of packets", in_ready, 0);
    chk(!overflow, "R9 no overflow when finished", overflow, 0);
    @(posedge clk); #1;
    drain("R8 drain");
    @(negedge clk);
    chk(in_ready, "R8 ready after drain", in_ready, 1);
    @(posedge clk); #1;

    // R9: full with open packet
    send(30, 'hC000, 4, 1, 0, 1);
    for (int i = 1; i < DEPTH - 1; i++) send(30, 'hC000 + i, 4, 0, 0, 1);
    @(negedge clk);
    chk(in_ready && !overflow, "R8 ready one short", {in_ready, overflow}, 2'b10);
    @(posedge clk); #1;
    send(30, 'hCFFF, 4, 0, 0, 1);
    @(negedge clk);
    chk(!in_ready && overflow && !out_valid, "R9 overflow", {in_ready, overflow, out_valid}, 3'b010);
    @(posedge clk); #1;
    sb.delete();
    do_reset();
    @(negedge clk);
    chk(!out_valid && !overflow && in_ready, "R1 reset after overflow",
        {out_valid, overflow, in_ready}, 3'b001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule